// File: doc/BRIEF.md
# Processor Core Timer Unit

This block gives one processor core its time-keeping hardware. It holds a free-running time base of up to 64 bits, a down-counting decrementer with an optional reload value, a periodic interval timer and a three-stage watchdog. A timer-clock enable pulse (`tick_en`) advances the time base and the decrementer. The interval timer and the watchdog both watch one time-base bit that software picks, and they react only when that bit goes from 0 to 1.

Software reaches the unit through a single-cycle write port and a combinational read port. A control word holds the period selects, the interrupt enables, the reload enable and the watchdog reset action. A status word records pending events. Software clears a status bit by writing a 1 to it. The unit drives three interrupt requests and one reset request. Each interrupt request is the AND of a status bit and its enable bit.

Top module: `cpu_tmr_unit`

## Requirements
- R1: After reset, the control word, status word, time base, decrementer and reload value all read 0, and all four request outputs are low.
- R2: Register map at both `wr_addr` and `rd_addr`: 0 control, 1 status, 2 decrementer, 3 reload value, 4 time base bits 31:0, 5 time base upper bits. Any other address reads 0. Each `tick_en` cycle adds one to the time base, with carry into the upper half. A write to address 4 or 5 replaces that half in place of counting.
- R3: While the decrementer is non-zero, each tick lowers it by one. On the step from 1 to 0 it sets status bit 27. A decrementer at 0 stays at 0.
- R4: Control bit 22 enables reload. If reload is enabled and the reload value is non-zero, the step that would reach 0 loads the reload value instead, and status bit 27 is still set. If the reload value is 0, the decrementer stays at 0 and sets no further flag.
- R5: A write to the status word clears each bit written as 1. Bits written as 0 keep their value. If hardware sets a bit in the same cycle that software clears it, the set wins.
- R6: Control bits 25:24 select one of four time-base bits, given by parameters, for the interval timer. Only a 0-to-1 change of the selected bit sets status bit 26. A falling bit does nothing. Changing the select does not create an event.
- R7: A rising edge of the interval bit while status bit 26 is already set is dropped. It is not remembered after software clears the bit.
- R8: Each watchdog event does one of the following. If status bit 31 is clear, it sets bit 31. Otherwise, if bit 30 is clear, it sets bit 30. Otherwise, if control bits 29:28 are non-zero and status bits 29:28 are zero, it copies control bits 29:28 into status bits 29:28. `wdt_rst_req` is high whenever status bits 29:28 are non-zero.
- R9: `dec_irq` = status 27 AND control 26. `fit_irq` = status 26 AND control 23. `wdt_irq` = status 30 AND control 27.
- R10: Control bits 31:30 select one of four time-base bits, given by parameters, for the watchdog. The watchdog uses the same rising-edge rule as the interval timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer-clock enable; advances time base and decrementer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| dec_irq | output | 1 | Decrementer interrupt request |
| fit_irq | output | 1 | Interval timer interrupt request |
| wdt_irq | output | 1 | Watchdog interrupt request |
| wdt_rst_req | output | 1 | Watchdog final-expiry reset request |

## Verification
The bench builds the unit with a full 64-bit time base and a 32-bit decrementer. The interval bits are set to 2, 3, 4 and 5, and the watchdog bits to 4, 5, 6 and 7. This replaces the deep default positions, so every interval edge, the whole three-stage watchdog sequence and both period selects occur within a few hundred ticks. The same setup makes rising and falling edges easy to place around status clears. A load of all ones into the low half, followed by one tick, checks the carry into the upper word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [2:0] {
      A_CTL = 3'd0,
      A_STS = 3'd1,
      A_DEC = 3'd2,
      A_RLD = 3'd3,
      A_TBL = 3'd4,
      A_TBH = 3'd5
   } tmr_addr_e;

   // control word fields
   localparam int unsigned C_WPER = 30;   // 2 bits, watchdog bit select
   localparam int unsigned C_WACT = 28;   // 2 bits, watchdog reset action
   localparam int unsigned C_WIEN = 27;
   localparam int unsigned C_DIEN = 26;
   localparam int unsigned C_FPER = 24;   // 2 bits, interval bit select
   localparam int unsigned C_FIEN = 23;
   localparam int unsigned C_RLEN = 22;

   // status word fields
   localparam int unsigned S_WARM = 31;
   localparam int unsigned S_WINT = 30;
   localparam int unsigned S_WRST = 28;   // 2 bits
   localparam int unsigned S_DINT = 27;
   localparam int unsigned S_FINT = 26;

   localparam logic [31:0] CTL_MASK = 32'hFFC0_0000;
   localparam logic [31:0] STS_MASK = 32'hFC00_0000;

endpackage

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
   parameter int TB_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            ld_lo,
   input  logic            ld_hi,
   input  logic [31:0]     wdata,
   output logic [TB_W-1:0] tb
);
   localparam int HI_W = TB_W - 32;

   if (TB_W < 33 || TB_W > 64) begin : g_bad_width
      $error("tmr_timebase: TB_W must lie in 33..64");
   end

   logic [TB_W-1:0] tb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tb_q <= '0;
      end else if (ld_lo) begin
         tb_q[31:0] <= wdata;
      end else if (ld_hi) begin
         tb_q[TB_W-1:32] <= wdata[HI_W-1:0];
      end else if (tick) begin
         tb_q <= tb_q + TB_W'(1);
      end
   end

   assign tb = tb_q;

   // R2: one tick, no load -> exactly one step
   a_r2_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld_lo && !ld_hi) |=> (tb_q == $past(tb_q) + TB_W'(1)));

endmodule

// File: rtl/tmr_bit_edge.sv
module tmr_bit_edge #(
   parameter int TB_W = 64,
   parameter int B0   = 21,
   parameter int B1   = 25,
   parameter int B2   = 29,
   parameter int B3   = 33
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TB_W-1:0] tb,
   input  logic [1:0]      sel,
   output logic            rise
);
   localparam int NSEL = 4;
   localparam int POS [NSEL] = '{B0, B1, B2, B3};

   logic [NSEL-1:0] seen_q;
   logic [NSEL-1:0] up;

   // every candidate bit keeps its own history so that a select change
   // never produces a false edge
   for (genvar i = 0; i < NSEL; i++) begin : g_tap
      if (POS[i] < 0 || POS[i] >= TB_W) begin : g_bad_pos
         $error("tmr_bit_edge: tap position outside time base");
      end
      always_ff @(posedge clk) begin
         if (!rst_n) seen_q[i] <= 1'b0;
         else        seen_q[i] <= tb[POS[i]];
      end
      assign up[i] = tb[POS[i]] & ~seen_q[i];
   end

   assign rise = up[sel];

   // R6: an edge cannot repeat on the next cycle without the tap falling
   a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && $stable(sel)) |=> !rise);

endmodule

// File: rtl/tmr_decrementer.sv
module tmr_decrementer #(
   parameter int DEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld,
   input  logic [DEC_W-1:0] ld_val,
   input  logic             reload_en,
   input  logic [DEC_W-1:0] reload_val,
   output logic [DEC_W-1:0] cnt,
   output logic             expire
);
   if (DEC_W < 2 || DEC_W > 32) begin : g_bad_width
      $error("tmr_decrementer: DEC_W must lie in 2..32");
   end

   logic [DEC_W-1:0] cnt_q;
   logic             reload_ok;

   assign expire    = tick && !ld && (cnt_q == DEC_W'(1));
   assign reload_ok = reload_en && (reload_val != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ld) begin
         cnt_q <= ld_val;
      end else if (tick && cnt_q != '0) begin
         if (cnt_q == DEC_W'(1)) cnt_q <= reload_ok ? reload_val : '0;
         else                    cnt_q <= cnt_q - DEC_W'(1);
      end
   end

   assign cnt = cnt_q;

   // R3: an idle zero count never moves on its own
   a_r3_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !ld) |=> (cnt_q == '0));

   // R4: a zero reload value leaves the count parked at zero
   a_r4_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && reload_val == '0) |=> (cnt_q == '0));

   // R4: a non-zero reload value is taken on expiry
   a_r4_reload_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && reload_en && reload_val != '0) |=> (cnt_q == $past(reload_val)));

endmodule

// File: rtl/cpu_tmr_unit.sv
module cpu_tmr_unit
   import tmr_pkg::*;
#(
   parameter int TB_W  = 64,
   parameter int DEC_W = 32,
   parameter int FIT_B0 = 21,
   parameter int FIT_B1 = 25,
   parameter int FIT_B2 = 29,
   parameter int FIT_B3 = 33,
   parameter int WDT_B0 = 29,
   parameter int WDT_B1 = 33,
   parameter int WDT_B2 = 37,
   parameter int WDT_B3 = 41
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_en,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic [2:0]  rd_addr,
   output logic [31:0] rd_data,
   output logic        dec_irq,
   output logic        fit_irq,
   output logic        wdt_irq,
   output logic        wdt_rst_req
);
   localparam int HI_W = TB_W - 32;

   logic [31:0]       ctl_q, sts_q, sts_set, sts_clr;
   logic [DEC_W-1:0]  rld_q, dec_cnt;
   logic [TB_W-1:0]   tb;
   logic [31:0]       tb_hi;
   logic              wr_ctl, wr_sts, wr_dec, wr_rld, wr_tbl, wr_tbh;
   logic              dec_exp, fit_rise, wdt_rise;

   // ---------------- write decode ----------------
   always_comb begin
      wr_ctl = 1'b0; wr_sts = 1'b0; wr_dec = 1'b0;
      wr_rld = 1'b0; wr_tbl = 1'b0; wr_tbh = 1'b0;
      if (wr_en) begin
         case (wr_addr)
            A_CTL:   wr_ctl = 1'b1;
            A_STS:   wr_sts = 1'b1;
            A_DEC:   wr_dec = 1'b1;
            A_RLD:   wr_rld = 1'b1;
            A_TBL:   wr_tbl = 1'b1;
            A_TBH:   wr_tbh = 1'b1;
            default: ;
         endcase
      end
   end

   // ---------------- sub-blocks ----------------
   tmr_timebase #(.TB_W(TB_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .tick(tick_en),
      .ld_lo(wr_tbl), .ld_hi(wr_tbh), .wdata(wr_data), .tb(tb)
   );

   tmr_decrementer #(.DEC_W(DEC_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .tick(tick_en),
      .ld(wr_dec), .ld_val(wr_data[DEC_W-1:0]),
      .reload_en(ctl_q[C_RLEN]), .reload_val(rld_q),
      .cnt(dec_cnt), .expire(dec_exp)
   );

   tmr_bit_edge #(.TB_W(TB_W), .B0(FIT_B0), .B1(FIT_B1), .B2(FIT_B2), .B3(FIT_B3)) u_fit_edge (
      .clk(clk), .rst_n(rst_n), .tb(tb), .sel(ctl_q[C_FPER +: 2]), .rise(fit_rise)
   );

   tmr_bit_edge #(.TB_W(TB_W), .B0(WDT_B0), .B1(WDT_B1), .B2(WDT_B2), .B3(WDT_B3)) u_wdt_edge (
      .clk(clk), .rst_n(rst_n), .tb(tb), .sel(ctl_q[C_WPER +: 2]), .rise(wdt_rise)
   );

   // ---------------- status set / clear ----------------
   always_comb begin
      sts_set          = '0;
      sts_set[S_DINT]  = dec_exp;
      sts_set[S_FINT]  = fit_rise & ~sts_q[S_FINT];
      if (wdt_rise) begin
         if (!sts_q[S_WARM])
            sts_set[S_WARM] = 1'b1;
         else if (!sts_q[S_WINT])
            sts_set[S_WINT] = 1'b1;
         else if (ctl_q[C_WACT +: 2] != 2'b00 && sts_q[S_WRST +: 2] == 2'b00)
            sts_set[S_WRST +: 2] = ctl_q[C_WACT +: 2];
      end
      sts_clr = wr_sts ? (wr_data & STS_MASK) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         sts_q <= '0;
         rld_q <= '0;
      end else begin
         if (wr_ctl) ctl_q <= wr_data & CTL_MASK;
         if (wr_rld) rld_q <= wr_data[DEC_W-1:0];
         sts_q <= ((sts_q & ~sts_clr) | sts_set) & STS_MASK;
      end
   end

   // ---------------- read path ----------------
   if (HI_W == 32) begin : g_hi_full
      assign tb_hi = tb[TB_W-1:32];
   end else begin : g_hi_part
      assign tb_hi = {{(32-HI_W){1'b0}}, tb[TB_W-1:32]};
   end

   always_comb begin
      case (rd_addr)
         A_CTL:   rd_data = ctl_q;
         A_STS:   rd_data = sts_q;
         A_DEC:   rd_data = 32'(dec_cnt);
         A_RLD:   rd_data = 32'(rld_q);
         A_TBL:   rd_data = tb[31:0];
         A_TBH:   rd_data = tb_hi;
         default: rd_data = '0;
      endcase
   end

   // ---------------- requests ----------------
   assign dec_irq     = sts_q[S_DINT] & ctl_q[C_DIEN];
   assign fit_irq     = sts_q[S_FINT] & ctl_q[C_FIEN];
   assign wdt_irq     = sts_q[S_WINT] & ctl_q[C_WIEN];
   assign wdt_rst_req = |sts_q[S_WRST +: 2];

   // R3: decrementer expiry is recorded in the status word
   a_r3_dec_flag: assert property (@(posedge clk) disable iff (!rst_n)
      dec_exp |=> sts_q[S_DINT]);

   // R5: a written 1 clears the interval flag when no new edge arrives
   a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && wr_data[S_FINT] && !fit_rise) |=> !sts_q[S_FINT]);

   // R8: the interrupt stage is only reached after the arm stage
   a_r8_wis_after_enw: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[S_WINT]) |-> $past(sts_q[S_WARM]));

   // R8: the reset request holds until software clears the reset status
   a_r8_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_rst_req && !(wr_sts && (wr_data[S_WRST +: 2] != 2'b00))) |=> wdt_rst_req);

endmodule

// File: tb/cpu_tmr_unit_bench.sv
module cpu_tmr_unit_bench;

   localparam logic [3:0] OP_W = 4'd0;   // write addr <- val
   localparam logic [3:0] OP_R = 4'd1;   // read addr, expect val
   localparam logic [3:0] OP_T = 4'd2;   // val ticks
   localparam logic [3:0] OP_I = 4'd3;   // expect {rst,wdt,fit,dec} = val[3:0]

   localparam logic [2:0] AC = 3'd0, AS = 3'd1, AD = 3'd2, AR = 3'd3, AL = 3'd4, AH = 3'd5;

   typedef struct packed {
      logic [3:0]  op;
      logic [3:0]  req;
      logic [2:0]  addr;
      logic [31:0] val;
   } vec_t;

   localparam int NV = 64;
   localparam vec_t VEC [NV] = '{
      '{OP_T, 4'd2,  AL, 32'd3},          // R2 tb -> 3
      '{OP_R, 4'd2,  AL, 32'd3},          // R2
      '{OP_T, 4'd6,  AL, 32'd1},          // R6 bit2 rises at tb=4
      '{OP_R, 4'd6,  AS, 32'h0400_0000},  // R6
      '{OP_W, 4'd5,  AS, 32'h0400_0000},  // R5 clear
      '{OP_T, 4'd6,  AL, 32'd4},          // R6 bit2 falls at 8
      '{OP_R, 4'd6,  AS, 32'h0000_0000},  // R6 no event on fall
      '{OP_W, 4'd6,  AC, 32'h0180_0000},  // R6 select bit3, FIE
      '{OP_T, 4'd6,  AL, 32'd16},         // R6 tb 8->24
      '{OP_R, 4'd6,  AS, 32'h8400_0000},  // R6 R8 arm from bit4
      '{OP_I, 4'd9,  AL, 32'd2},          // R9
      '{OP_T, 4'd7,  AL, 32'd16},         // R7 tb 24->40, rise while pending
      '{OP_W, 4'd7,  AS, 32'h0400_0000},  // R7
      '{OP_R, 4'd5,  AS, 32'h8000_0000},  // R5 zero bits untouched
      '{OP_T, 4'd7,  AL, 32'd7},          // R7 tb -> 47
      '{OP_R, 4'd7,  AS, 32'h8000_0000},  // R7 dropped edge not kept
      '{OP_T, 4'd8,  AL, 32'd1},          // R8 tb 48
      '{OP_R, 4'd8,  AS, 32'hC000_0000},  // R8
      '{OP_W, 4'd9,  AC, 32'h2980_0000},  // R9 WIE, action 2
      '{OP_I, 4'd9,  AL, 32'd4},          // R9
      '{OP_T, 4'd8,  AL, 32'd32},         // R8 tb 48->80
      '{OP_R, 4'd8,  AS, 32'hE400_0000},  // R8
      '{OP_I, 4'd8,  AL, 32'd14},         // R8
      '{OP_W, 4'd5,  AS, 32'hF400_0000},  // R5
      '{OP_R, 4'd5,  AS, 32'h0000_0000},  // R5
      '{OP_I, 4'd8,  AL, 32'd0},          // R8 reset request drops
      '{OP_W, 4'd10, AC, 32'h6980_0000},  // R10 watchdog bit5
      '{OP_T, 4'd10, AL, 32'd16},         // R10 tb 80->96
      '{OP_R, 4'd10, AS, 32'h8400_0000},  // R10
      '{OP_W, 4'd5,  AS, 32'h8400_0000},  // R5
      '{OP_W, 4'd3,  AC, 32'hC700_0000},  // R3 DIE, taps 5 and 7
      '{OP_W, 4'd3,  AD, 32'd5},          // R3
      '{OP_T, 4'd3,  AL, 32'd4},          // R3
      '{OP_R, 4'd3,  AD, 32'd1},          // R3
      '{OP_T, 4'd3,  AL, 32'd1},          // R3
      '{OP_R, 4'd3,  AD, 32'd0},          // R3
      '{OP_R, 4'd3,  AS, 32'h0800_0000},  // R3
      '{OP_T, 4'd3,  AL, 32'd2},          // R3
      '{OP_R, 4'd3,  AD, 32'd0},          // R3 stays at zero
      '{OP_W, 4'd5,  AS, 32'h0800_0000},  // R5
      '{OP_W, 4'd4,  AR, 32'd3},          // R4
      '{OP_W, 4'd4,  AC, 32'hC740_0000},  // R4 reload on
      '{OP_W, 4'd4,  AD, 32'd2},          // R4
      '{OP_T, 4'd4,  AL, 32'd2},          // R4
      '{OP_R, 4'd4,  AD, 32'd3},          // R4
      '{OP_W, 4'd4,  AS, 32'h0800_0000},  // R4
      '{OP_T, 4'd4,  AL, 32'd3},          // R4
      '{OP_R, 4'd4,  AD, 32'd3},          // R4
      '{OP_R, 4'd4,  AS, 32'h0800_0000},  // R4
      '{OP_W, 4'd4,  AS, 32'h0800_0000},  // R4
      '{OP_W, 4'd4,  AR, 32'd0},          // R4 zero reload
      '{OP_W, 4'd4,  AD, 32'd1},          // R4
      '{OP_T, 4'd4,  AL, 32'd1},          // R4
      '{OP_R, 4'd4,  AD, 32'd0},          // R4
      '{OP_W, 4'd4,  AS, 32'h0800_0000},  // R4
      '{OP_T, 4'd4,  AL, 32'd3},          // R4
      '{OP_R, 4'd4,  AD, 32'd0},          // R4
      '{OP_R, 4'd4,  AS, 32'h0000_0000},  // R4 no retrigger
      '{OP_W, 4'd2,  AL, 32'hFFFF_FFFF},  // R2
      '{OP_W, 4'd2,  AH, 32'd1},          // R2
      '{OP_T, 4'd2,  AL, 32'd1},          // R2 carry
      '{OP_R, 4'd2,  AH, 32'd2},          // R2
      '{OP_R, 4'd2,  AL, 32'd0},          // R2
      '{OP_R, 4'd10, AS, 32'h8000_0000}   // R10 bit7 rose on load
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        dec_irq, fit_irq, wdt_irq, wdt_rst_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   cpu_tmr_unit #(
      .TB_W(64), .DEC_W(32),
      .FIT_B0(2), .FIT_B1(3), .FIT_B2(4), .FIT_B3(5),
      .WDT_B0(4), .WDT_B1(5), .WDT_B2(6), .WDT_B3(7)
   ) u_cpu_tmr_unit (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .dec_irq(dec_irq), .fit_irq(fit_irq), .wdt_irq(wdt_irq),
      .wdt_rst_req(wdt_rst_req)
   );

   task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic rd_chk(input int req, input logic [2:0] a, input logic [31:0] exp);
      @(negedge clk);
      rd_addr = a;
      #1;
      chk(req, $sformatf("read addr %0d", a), rd_data, exp);
   endtask

   task automatic irq_chk(input int req, input logic [3:0] exp);
      @(negedge clk);
      #1;
      chk(req, "requests {rst,wdt,fit,dec}",
          {28'd0, wdt_rst_req, wdt_irq, fit_irq, dec_irq}, {28'd0, exp});
   endtask

   task automatic reset_checks;
      rd_chk(1, AC, 32'd0);   // R1
      rd_chk(1, AS, 32'd0);   // R1
      rd_chk(1, AL, 32'd0);   // R1
      rd_chk(1, AH, 32'd0);   // R1
      rd_chk(1, AD, 32'd0);   // R1
      rd_chk(1, AR, 32'd0);   // R1
      irq_chk(1, 4'd0);       // R1
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      reset_checks();

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VEC[i];
         case (v.op)
            OP_W:    do_wr(v.addr, v.val);
            OP_R:    rd_chk(int'(v.req), v.addr, v.val);
            OP_T:    do_ticks(int'(v.val));
            default: irq_chk(int'(v.req), v.val[3:0]);
         endcase
      end

      // R2: unmapped address reads zero
      rd_chk(2, 3'd6, 32'd0);

      // R5: set wins over a simultaneous clear (bit2 rises on this tick)
      do_wr(AC, 32'h0000_0000);
      do_wr(AL, 32'd3);
      do_wr(AS, 32'hFC00_0000);
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      wr_en = 1'b1; wr_addr = AS; wr_data = 32'h0400_0000;
      @(negedge clk); wr_en = 1'b0;
      rd_chk(5, AS, 32'h0400_0000);

      // R1: reset in the middle of activity
      do_wr(AC, 32'hFFC0_0000);
      do_wr(AD, 32'd9);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      reset_checks();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule